// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a two-part logical address, a segment number plus an offset inside that segment, into a physical address. It looks the segment up in a small table of descriptors held in local registers. Each descriptor carries a physical start address, a segment length, a validity flag and three access-right flags (read, write, execute). A separate count register states how many of the table's slots a program may use.

Every access passes four checks in a fixed priority order. The first is the segment number against the count. The second is the validity flag. The third is the offset against the length. The last is the access kind against the rights. The first failing check selects a distinct trap code. When every check passes, the block returns start address plus offset. The result is registered and appears one cycle after the request. Software fills the table and the count through a simple write port. A descriptor write in the same cycle as a lookup of that slot is seen only by later lookups.

Top module: `segx_unit`

## Requirements
- R1: After reset, the segment count is 0 and every descriptor is invalid. A request made right after reset therefore returns trap code 1.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. While `rsp_valid` is low, `rsp_trap` and `rsp_paddr` are 0.
- R3: A segment number greater than or equal to the segment count gives trap code 1 (out of range).
- R4: A descriptor whose validity flag is 0 gives trap code 2 (invalid segment).
- R5: An offset greater than or equal to the descriptor's length gives trap code 3 (beyond limit). A length of 0 makes every offset fail.
- R6: The access kind is encoded 0 read, 1 write, 2 execute, 3 reserved. The rights field holds bit 0 read, bit 1 write and bit 2 execute. An access whose right bit is 0 gives trap code 4 (permission denied). Kind 3 is always denied.
- R7: An access that passes all checks returns trap code 0 and physical address = start + offset, taken modulo 2^BASE_W.
- R8: Whenever the trap code is non-zero, `rsp_paddr` is 0.
- R9: A descriptor write in the same cycle as a lookup of the same slot leaves that lookup's result on the old contents. The next lookup sees the new contents.
- R10: A count write above SEG_COUNT saturates to SEG_COUNT.
- R11: When several checks fail, the trap code is that of the first failing check in the order R3, R4, R5, R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 3 | Descriptor slot to write |
| cfg_base | input | 24 | Physical start address |
| cfg_limit | input | 17 | Segment length in bytes (0 to 65536) |
| cfg_valid | input | 1 | Validity flag |
| cfg_perm | input | 3 | Rights: bit0 read, bit1 write, bit2 execute |
| len_we | input | 1 | Segment count write strobe |
| len_val | input | 4 | New segment count |
| req_valid | input | 1 | Lookup request |
| req_seg | input | 3 | Segment number |
| req_off | input | 16 | Offset inside segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_trap | output | 3 | 0 none, 1 range, 2 invalid, 3 limit, 4 permission |
| rsp_paddr | output | 24 | Physical address, 0 on trap |

## Verification
Some rules are checked by assertions on every cycle: the one-cycle response timing, quiet outputs when idle, a zero address on any trap, an out-of-range segment giving code 1 whatever the descriptor holds, and a count that never exceeds the table size. Other behaviour only the bench scenarios can show. These are the exact arithmetic of start plus offset including wrap-around, the rights decoding for each access kind, the priority between checks that fail together, the old-contents result for a same-cycle descriptor write, and saturation of the count.

// File: rtl/segx_pkg.sv
// Package: shared trap codes, access kinds and the rights-decoding helper
// for the segment translation unit. Assumes the rights field has three bits:
// bit 0 read, bit 1 write, bit 2 execute.
package segx_pkg;

    typedef enum logic [2:0] {
        TRAP_NONE    = 3'd0,
        TRAP_RANGE   = 3'd1,
        TRAP_INVALID = 3'd2,
        TRAP_LIMIT   = 3'd3,
        TRAP_PERM    = 3'd4
    } trap_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam int PERM_W = 3;

    // Rights mask needed by an access kind; the reserved kind needs none and is never granted
    function automatic logic [PERM_W-1:0] need_mask(input logic [1:0] acc);
        case (acc)
            ACC_READ:  need_mask = 3'b001;
            ACC_WRITE: need_mask = 3'b010;
            ACC_EXEC:  need_mask = 3'b100;
            default:   need_mask = 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/segx_table.sv
// Module: descriptor storage and the segment-count register.
// Holds SEG_COUNT descriptors (start, length, validity, rights) in flops and
// gives an asynchronous read of one slot. Writes land at the clock edge, so
// a lookup in the same cycle sees the old contents. Assumes cfg_idx values
// at or above SEG_COUNT are dropped.
module segx_table
    import segx_pkg::*;
#(
    parameter int SEG_COUNT = 8,
    parameter int OFF_W     = 16,
    parameter int BASE_W    = 24,
    localparam int SEG_W    = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1,
    localparam int LEN_W    = $clog2(SEG_COUNT + 1),
    localparam int LIM_W    = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEG_W-1:0]  cfg_idx,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic [LIM_W-1:0]  cfg_limit,
    input  logic              cfg_valid,
    input  logic [PERM_W-1:0] cfg_perm,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_val,
    input  logic [SEG_W-1:0]  rd_idx,
    output logic [BASE_W-1:0] rd_base,
    output logic [LIM_W-1:0]  rd_limit,
    output logic              rd_valid,
    output logic [PERM_W-1:0] rd_perm,
    output logic [LEN_W-1:0]  seg_len
);

    logic [BASE_W-1:0] base_q  [SEG_COUNT];
    logic [LIM_W-1:0]  limit_q [SEG_COUNT];
    logic              valid_q [SEG_COUNT];
    logic [PERM_W-1:0] perm_q  [SEG_COUNT];
    logic [LEN_W-1:0]  len_q;

    // One register group per slot, written when the index matches
    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g]  <= '0;
                limit_q[g] <= '0;
                valid_q[g] <= 1'b0;
                perm_q[g]  <= '0;
            end else if (cfg_we && (cfg_idx == SEG_W'(g))) begin
                base_q[g]  <= cfg_base;
                limit_q[g] <= cfg_limit;
                valid_q[g] <= cfg_valid;
                perm_q[g]  <= cfg_perm;
            end
        end
    end

    // Segment count register, saturating at the table size
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (len_we) begin
            len_q <= (len_val > LEN_W'(SEG_COUNT)) ? LEN_W'(SEG_COUNT) : len_val;
        end
    end

    // Asynchronous read of the addressed slot; out-of-table indices read as invalid
    always_comb begin
        rd_base  = '0;
        rd_limit = '0;
        rd_valid = 1'b0;
        rd_perm  = '0;
        for (int i = 0; i < SEG_COUNT; i++) begin
            if (rd_idx == SEG_W'(i)) begin
                rd_base  = base_q[i];
                rd_limit = limit_q[i];
                rd_valid = valid_q[i];
                rd_perm  = perm_q[i];
            end
        end
    end

    assign seg_len = len_q;

    // The count never exceeds the table size (R10)
    assert_len_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seg_len <= LEN_W'(SEG_COUNT));

    // A count write is reflected, saturated, on the next cycle (R10)
    assert_len_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (len_we && len_val > LEN_W'(SEG_COUNT)) |=> (seg_len == LEN_W'(SEG_COUNT)));

endmodule

// File: rtl/segx_check.sv
// Module: combinational access check and address formation.
// Applies the four checks in priority order (range, validity, limit, rights)
// and forms start + offset. Assumes BASE_W >= OFF_W; the sum wraps modulo
// 2^BASE_W. The address output is forced to 0 whenever a trap is raised.
module segx_check
    import segx_pkg::*;
#(
    parameter int SEG_COUNT = 8,
    parameter int OFF_W     = 16,
    parameter int BASE_W    = 24,
    localparam int SEG_W    = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1,
    localparam int LEN_W    = $clog2(SEG_COUNT + 1),
    localparam int LIM_W    = OFF_W + 1
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        acc,
    input  logic [LEN_W-1:0]  seg_len,
    input  logic [BASE_W-1:0] ent_base,
    input  logic [LIM_W-1:0]  ent_limit,
    input  logic              ent_valid,
    input  logic [PERM_W-1:0] ent_perm,
    output trap_e             trap,
    output logic [BASE_W-1:0] paddr
);

    logic              fail_range;
    logic              fail_valid;
    logic              fail_limit;
    logic              fail_perm;
    logic [BASE_W-1:0] sum;

    // Individual check results, each independent of the others
    always_comb begin
        fail_range = ({1'b0, seg} >= (SEG_W + 1)'(seg_len));
        fail_valid = !ent_valid;
        fail_limit = ({1'b0, off} >= ent_limit);
        fail_perm  = ((ent_perm & need_mask(acc)) == '0);
        sum        = ent_base + BASE_W'(off);
    end

    // Priority encode the first failing check and gate the address
    always_comb begin
        if (fail_range)      trap = TRAP_RANGE;
        else if (fail_valid) trap = TRAP_INVALID;
        else if (fail_limit) trap = TRAP_LIMIT;
        else if (fail_perm)  trap = TRAP_PERM;
        else                 trap = TRAP_NONE;
        paddr = (trap == TRAP_NONE) ? sum : '0;
    end

endmodule

// File: rtl/segx_resp.sv
// Module: response register stage.
// Captures the check result one cycle after a request and drives zeros while
// no request was made. Assumes its inputs are already gated on trap.
module segx_resp
    import segx_pkg::*;
#(
    parameter int BASE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  trap_e             trap_in,
    input  logic [BASE_W-1:0] paddr_in,
    output logic              rsp_valid,
    output logic [2:0]        rsp_trap,
    output logic [BASE_W-1:0] rsp_paddr
);

    // Register the result of a request; clear outputs when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_trap  <= '0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_trap  <= req_valid ? trap_in  : '0;
            rsp_paddr <= req_valid ? paddr_in : '0;
        end
    end

    // Response follows a request by exactly one cycle (R2)
    assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // No request, no response on the next cycle (R2)
    assert_resp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // Idle outputs stay at zero (R2)
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_trap == 3'd0 && rsp_paddr == '0));

    // A trapped access never exposes an address (R8)
    assert_trap_zero_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_trap != 3'd0) |-> (rsp_paddr == '0));

    // Only defined trap codes appear (R11)
    assert_trap_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap <= 3'd4);

endmodule

// File: rtl/segx_unit.sv
// Module: top of the segment translation and protection unit.
// Connects descriptor storage, the combinational check and the response
// register. Assumes BASE_W >= OFF_W. The result of a request appears one
// cycle later on the rsp_* outputs.
module segx_unit
    import segx_pkg::*;
#(
    parameter int SEG_COUNT = 8,
    parameter int OFF_W     = 16,
    parameter int BASE_W    = 24,
    localparam int SEG_W    = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1,
    localparam int LEN_W    = $clog2(SEG_COUNT + 1),
    localparam int LIM_W    = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEG_W-1:0]  cfg_idx,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic [LIM_W-1:0]  cfg_limit,
    input  logic              cfg_valid,
    input  logic [2:0]        cfg_perm,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_val,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              rsp_valid,
    output logic [2:0]        rsp_trap,
    output logic [BASE_W-1:0] rsp_paddr
);

    logic [BASE_W-1:0] ent_base;
    logic [LIM_W-1:0]  ent_limit;
    logic              ent_valid;
    logic [PERM_W-1:0] ent_perm;
    logic [LEN_W-1:0]  seg_len;
    trap_e             chk_trap;
    logic [BASE_W-1:0] chk_paddr;

    segx_table #(.SEG_COUNT(SEG_COUNT), .OFF_W(OFF_W), .BASE_W(BASE_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_base  (cfg_base),
        .cfg_limit (cfg_limit),
        .cfg_valid (cfg_valid),
        .cfg_perm  (cfg_perm),
        .len_we    (len_we),
        .len_val   (len_val),
        .rd_idx    (req_seg),
        .rd_base   (ent_base),
        .rd_limit  (ent_limit),
        .rd_valid  (ent_valid),
        .rd_perm   (ent_perm),
        .seg_len   (seg_len)
    );

    segx_check #(.SEG_COUNT(SEG_COUNT), .OFF_W(OFF_W), .BASE_W(BASE_W)) u_check (
        .seg       (req_seg),
        .off       (req_off),
        .acc       (req_acc),
        .seg_len   (seg_len),
        .ent_base  (ent_base),
        .ent_limit (ent_limit),
        .ent_valid (ent_valid),
        .ent_perm  (ent_perm),
        .trap      (chk_trap),
        .paddr     (chk_paddr)
    );

    segx_resp #(.BASE_W(BASE_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .trap_in   (chk_trap),
        .paddr_in  (chk_paddr),
        .rsp_valid (rsp_valid),
        .rsp_trap  (rsp_trap),
        .rsp_paddr (rsp_paddr)
    );

    // Out-of-range segment wins over every other check (R3, R11)
    assert_range_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_seg} >= (SEG_W + 1)'(seg_len))) |=> (rsp_trap == 3'd1));

    // In-range invalid descriptor yields the invalid-segment code (R4)
    assert_invalid_seg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_seg} < (SEG_W + 1)'(seg_len)) && !ent_valid)
        |=> (rsp_trap == 3'd2));

endmodule

// File: tb/segx_unit_bench.sv
// Directed bench for segx_unit: a shadow descriptor model computes expected
// trap codes and addresses from the requirements; one task per scenario.
module segx_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [23:0] cfg_base;
    logic [16:0] cfg_limit;
    logic        cfg_valid;
    logic [2:0]  cfg_perm;
    logic        len_we;
    logic [3:0]  len_val;
    logic        req_valid;
    logic [2:0]  req_seg;
    logic [15:0] req_off;
    logic [1:0]  req_acc;
    logic        rsp_valid;
    logic [2:0]  rsp_trap;
    logic [23:0] rsp_paddr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [23:0] m_base  [8];
    logic [16:0] m_limit [8];
    logic        m_valid [8];
    logic [2:0]  m_perm  [8];
    int          m_len;

    always #5 clk = ~clk;

    segx_unit u_segx_unit (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_valid(cfg_valid), .cfg_perm(cfg_perm),
        .len_we(len_we), .len_val(len_val),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_paddr(rsp_paddr)
    );

    function automatic int exp_trap(int s, int o, int a);
        logic [2:0] need;
        need = (a == 0) ? 3'b001 : (a == 1) ? 3'b010 : (a == 2) ? 3'b100 : 3'b000;
        if (s >= m_len) return 1;
        if (!m_valid[s]) return 2;
        if (o >= int'(m_limit[s])) return 3;
        if ((m_perm[s] & need) == 3'b000) return 4;
        return 0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_desc(int i, logic [23:0] b, logic [16:0] l, bit v, logic [2:0] p);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(i); cfg_base = b; cfg_limit = l;
        cfg_valid = v; cfg_perm = p;
        @(negedge clk);
        cfg_we = 1'b0;
        m_base[i] = b; m_limit[i] = l; m_valid[i] = v; m_perm[i] = p;
    endtask

    task automatic write_len(int n);
        @(negedge clk);
        len_we = 1'b1; len_val = 4'(n);
        @(negedge clk);
        len_we = 1'b0;
        m_len = (n > 8) ? 8 : n;
    endtask

    // Issue one request and compare both outputs with the model
    task automatic lookup(string tag, int s, int o, int a);
        int          et;
        logic [23:0] ea;
        @(negedge clk);
        et = exp_trap(s, o, a);
        ea = (et == 0) ? 24'(m_base[s] + 24'(o)) : 24'h0;
        req_valid = 1'b1; req_seg = 3'(s); req_off = 16'(o); req_acc = 2'(a);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " trap"}, 32'(rsp_trap), 32'(et));
        check({tag, " paddr R8"}, 32'(rsp_paddr), 32'(ea));
    endtask

    task automatic t_reset;
        check("R1 idle valid", 32'(rsp_valid), 32'd0);
        check("R1 idle trap", 32'(rsp_trap), 32'd0);
        check("R1 idle paddr", 32'(rsp_paddr), 32'd0);
        lookup("R1 first request", 0, 0, 0);
        check("R1 code after reset", 32'(rsp_trap), 32'd1);
    endtask

    task automatic t_idle;
        @(negedge clk);
        check("R2 no request valid", 32'(rsp_valid), 32'd0);
        check("R2 no request paddr", 32'(rsp_paddr), 32'd0);
    endtask

    task automatic t_range;
        write_len(3);
        lookup("R3 seg at count", 3, 0, 0);
        lookup("R3 seg 7", 7, 0, 0);
        lookup("R4 in range unwritten", 2, 0, 0);
    endtask

    task automatic t_limit_and_legal;
        write_desc(0, 24'h100000, 17'h100, 1'b1, 3'b011);
        write_desc(1, 24'h200000, 17'h0, 1'b1, 3'b111);
        lookup("R7 last byte", 0, 16'hFF, 0);
        check("R7 sum", 32'(rsp_paddr), 32'h1000FF);
        lookup("R5 offset at limit", 0, 16'h100, 0);
        lookup("R5 zero length", 1, 0, 0);
        write_desc(2, 24'hFFFFF0, 17'h10000, 1'b1, 3'b111);
        lookup("R7 wrap", 2, 16'h20, 1);
        check("R7 wrap value", 32'(rsp_paddr), 32'h000010);
        lookup("R7 full length", 2, 16'hFFFF, 2);
    endtask

    task automatic t_perm;
        lookup("R6 write allowed", 0, 4, 1);
        lookup("R6 exec denied", 0, 4, 2);
        lookup("R6 reserved kind", 0, 4, 3);
        write_desc(3, 24'h000400, 17'h40, 1'b1, 3'b100);
        write_len(4);
        lookup("R6 read denied exec-only", 3, 1, 0);
        lookup("R6 exec allowed", 3, 1, 2);
    endtask

    task automatic t_priority;
        write_desc(4, 24'h0, 17'h0, 1'b0, 3'b000);
        write_desc(5, 24'h0, 17'h0, 1'b1, 3'b000);
        write_len(6);
        lookup("R11 invalid over limit", 4, 9, 3);
        check("R11 code 2", 32'(rsp_trap), 32'd2);
        lookup("R11 limit over perm", 5, 9, 3);
        check("R11 code 3", 32'(rsp_trap), 32'd3);
        write_len(1);
        lookup("R11 range over all", 5, 9, 3);
        check("R11 code 1", 32'(rsp_trap), 32'd1);
        write_len(6);
    endtask

    // Descriptor write and lookup of the same slot in one cycle
    task automatic t_same_cycle;
        @(negedge clk);
        req_valid = 1'b1; req_seg = 3'd0; req_off = 16'h10; req_acc = 2'd0;
        cfg_we = 1'b1; cfg_idx = 3'd0; cfg_base = 24'h300000; cfg_limit = 17'h100;
        cfg_valid = 1'b1; cfg_perm = 3'b001;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        check("R9 old contents", 32'(rsp_paddr), 32'h100010);
        m_base[0] = 24'h300000; m_perm[0] = 3'b001;
        lookup("R9 new contents", 0, 16'h10, 0);
        check("R9 new value", 32'(rsp_paddr), 32'h300010);
    endtask

    task automatic t_len_sat;
        write_len(15);
        lookup("R10 seg 7 in range", 7, 0, 0);
        check("R10 not range trap", 32'(rsp_trap), 32'd2);
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_base = '0; cfg_limit = '0;
        cfg_valid = 1'b0; cfg_perm = '0; len_we = 1'b0; len_val = '0;
        req_valid = 1'b0; req_seg = '0; req_off = '0; req_acc = '0;
        for (int i = 0; i < 8; i++) begin
            m_base[i] = '0; m_limit[i] = '0; m_valid[i] = 1'b0; m_perm[i] = '0;
        end
        m_len = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_range();
        t_limit_and_legal();
        t_perm();
        t_priority();
        t_same_cycle();
        t_len_sat();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule